// File: doc/BRIEF.md
# Phase-Selectable Half-Rate Clock Generator

This block runs on a reference clock and drives a small bank of output waveforms at half the reference rate with a 50% duty cycle. Every output can take either the in-phase or the inverted copy of the divided clock. Each output has its own select bit. An all-zero select parks the whole bank low, and an active-low power-down input also forces every output low. All outputs are registers in the reference clock domain.

Select and power-down inputs are sampled on the rising reference edge into a shadow stage. A new select pattern is copied into the active register only when a fresh output cycle begins. Every output level therefore lasts a whole number of reference cycles, and a switch cannot shorten a pulse.

A three-state sequencer drives the timing. The states are `PS_OFF` (parked, outputs low), `PS_FIRST` (first half of an output cycle) and `PS_SECOND` (second half). The transitions are:
- *wake*: `PS_OFF`→`PS_FIRST`, when the sampled power-down is high.
- *half*: `PS_FIRST`→`PS_SECOND`.
- *wrap*: `PS_SECOND`→`PS_FIRST`, which is the output-cycle boundary where the select loads.
- *sleep*: any state→`PS_OFF`, when the sampled power-down is low.

Top module: `halfrate_phase_gen`

## Requirements
- R1: With power up and a nonzero active select, every output changes level on every reference edge. This gives a period of two reference cycles at a 50% duty cycle.
- R2: An output whose select bit is 1 is high in the first half of each output cycle and low in the second half. An output whose bit is 0 has the opposite levels. Select bit n controls output n.
- R3: While the active select is 4'b0000, all outputs are low. A later nonzero select restores toggling outputs.
- R4: A select change is applied only at the next output-cycle start that follows the sampling edge. The new pattern is visible 2 reference edges after the change when the change is made in the first half, and 3 edges after it when made in the second half. The old pattern continues unchanged until then.
- R5: If pd_n is sampled low on edge s, the outputs stay unchanged through edge s and are all low from edge s+1 on.
- R6: If pd_n is sampled high on edge s while parked, the outputs are low after edge s. A new output cycle starts at edge s+1, using the select that was sampled at edge s, including a select changed in the same cycle.
- R7: The synchronous active-high reset clears all outputs to low. With pd_n high and a select given during reset, the first edge after reset keeps the outputs low. The second edge starts an output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phase_sel | input | N_OUT | Per-output phase choice: 1 selects in-phase, 0 selects inverted; all zero parks the outputs low |
| pd_n | input | 1 | Active-low power-down |
| clk_out | output | N_OUT | Registered half-rate outputs |

## Verification
Two events can land on the same reference edge: the release of power-down and a select change. The bench makes both happen at once by driving a new select in the same cycle that pd_n rises. It then checks that the first output cycle after wake shows the new pattern and not the pattern in force before power-down. A second case asserts power-down in the second half of an output cycle. The bench checks that the first half of the next cycle still completes before the outputs park.

// File: rtl/hpg_pkg.sv
package hpg_pkg;
    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_FIRST  = 2'd1,
        PS_SECOND = 2'd2
    } phase_e;
endpackage

// File: rtl/hpg_phase_seq.sv
module hpg_phase_seq
    import hpg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pd_n,
    output phase_e state_q,
    output phase_e state_d,
    output logic   cyc_start
);
    logic pd_q;

    // state register and power-down sample stage
    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q    <= 1'b0;
            state_q <= PS_OFF;
        end else begin
            pd_q    <= pd_n;
            state_q <= state_d;
        end
    end

    // next-state decode: wake, half, wrap, sleep
    always_comb begin
        unique case (state_q)
            PS_OFF:    state_d = pd_q ? PS_FIRST  : PS_OFF;
            PS_FIRST:  state_d = pd_q ? PS_SECOND : PS_OFF;
            PS_SECOND: state_d = pd_q ? PS_FIRST  : PS_OFF;
            default:   state_d = PS_OFF;
        endcase
    end

    assign cyc_start = (state_d == PS_FIRST);

    // R1: a first half is always followed by a second half or by parking
    a_r1_no_double_first: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_FIRST) |=> (state_q != PS_FIRST));
endmodule

// File: rtl/hpg_sel_stage.sv
module hpg_sel_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sel_in,
    input  logic         load,
    output logic [W-1:0] act_q,
    output logic [W-1:0] act_d
);
    logic [W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            act_q <= '0;
        end else begin
            sel_q <= sel_in;
            act_q <= act_d;
        end
    end

    always_comb act_d = load ? sel_q : act_q;
endmodule

// File: rtl/hpg_out_drive.sv
module hpg_out_drive
    import hpg_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  phase_e       state_d,
    input  logic [W-1:0] act_d,
    output logic [W-1:0] out_q
);
    logic [W-1:0] out_d;
    logic         any_on;

    assign any_on = (act_d != '0);

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_comb
            out_d[g] = any_on &&
                       (((state_d == PS_FIRST)  &&  act_d[g]) ||
                        ((state_d == PS_SECOND) && !act_d[g]));
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end
endmodule

// File: rtl/halfrate_phase_gen.sv
module halfrate_phase_gen
    import hpg_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  logic             ref_clk,
    input  logic             rst,
    input  logic [N_OUT-1:0] phase_sel,
    input  logic             pd_n,
    output logic [N_OUT-1:0] clk_out
);
    phase_e           state_q;
    phase_e           state_d;
    logic             cyc_start;
    logic [N_OUT-1:0] act_q;
    logic [N_OUT-1:0] act_d;

    hpg_phase_seq u_seq (
        .clk       (ref_clk),
        .rst       (rst),
        .pd_n      (pd_n),
        .state_q   (state_q),
        .state_d   (state_d),
        .cyc_start (cyc_start)
    );

    hpg_sel_stage #(.W(N_OUT)) u_sel (
        .clk    (ref_clk),
        .rst    (rst),
        .sel_in (phase_sel),
        .load   (cyc_start),
        .act_q  (act_q),
        .act_d  (act_d)
    );

    hpg_out_drive #(.W(N_OUT)) u_out (
        .clk     (ref_clk),
        .rst     (rst),
        .state_d (state_d),
        .act_d   (act_d),
        .out_q   (clk_out)
    );

    // R1: second half is the complement of the first half
    a_r1_half_swap: assert property (@(posedge ref_clk) disable iff (rst)
        ((state_q == PS_SECOND) && (act_q != '0)) |-> (clk_out == ~$past(clk_out)));

    // R2: in the first half each output equals its select bit
    for (genvar g = 0; g < N_OUT; g++) begin : g_chk
        a_r2_lead: assert property (@(posedge ref_clk) disable iff (rst)
            ((state_q == PS_FIRST) && (act_q != '0)) |-> (clk_out[g] == act_q[g]));
    end

    // R3: all-zero active select keeps the bank low
    a_r3_quiet: assert property (@(posedge ref_clk) disable iff (rst)
        (act_q == '0) |-> (clk_out == '0));

    // R4: the active select moves only at an output-cycle start
    a_r4_edge_only: assert property (@(posedge ref_clk) disable iff (rst)
        !$stable(act_q) |-> (state_q == PS_FIRST));

    // R5: power-down sampled low parks outputs one edge later
    a_r5_park: assert property (@(posedge ref_clk) disable iff (rst)
        !$past(pd_n, 2) |-> (clk_out == '0));
endmodule

// File: tb/halfrate_phase_gen_bench.sv
module halfrate_phase_gen_bench;
    logic       ref_clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_n = 1'b1;
    logic [3:0] phase_sel = 4'hF;
    logic [3:0] clk_out;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    halfrate_phase_gen #(.N_OUT(4)) u_halfrate_phase_gen (
        .ref_clk   (ref_clk),
        .rst       (rst),
        .phase_sel (phase_sel),
        .pd_n      (pd_n),
        .clk_out   (clk_out)
    );

    always #10 ref_clk = ~ref_clk;

    task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge ref_clk);
    endtask

    // stop right after an edge that began a first half with select all ones
    task automatic align();
        for (int i = 0; i < 6; i++) begin
            step();
            if (clk_out == 4'hF) break;
        end
    endtask

    task automatic restore();
        phase_sel = 4'hF;
        repeat (4) step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R7 held in reset", clk_out, 4'h0);
        rst = 1'b0;
        step(); chk("R7 first edge after reset", clk_out, 4'h0);
        step(); chk("R7 first cycle start", clk_out, 4'hF);
        step(); chk("R7 first second half", clk_out, 4'h0);
    endtask

    task automatic t_steady(input logic [3:0] x);
        align();
        phase_sel = x;
        step(); chk("R4 old pattern kept", clk_out, 4'h0);
        step(); chk("R2 first half follows select", clk_out, x);
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R1 toggle each edge", clk_out, (i % 2 == 0) ? ~x : x);
        end
        restore();
    endtask

    task automatic t_late(input logic [3:0] x);
        align();
        step(); chk("R1 second half low", clk_out, 4'h0);
        phase_sel = x;
        step(); chk("R4 late change old first half", clk_out, 4'hF);
        step(); chk("R4 late change old second half", clk_out, 4'h0);
        step(); chk("R4 late change applied", clk_out, x);
        restore();
    endtask

    task automatic t_zero();
        logic [3:0] prev;
        align();
        phase_sel = 4'h0;
        step(); chk("R3 before load", clk_out, 4'h0);
        for (int i = 0; i < 5; i++) begin
            step(); chk("R3 parked by zero select", clk_out, 4'h0);
        end
        phase_sel = 4'hF;
        repeat (4) step();
        prev = clk_out;
        step(); chk("R3 toggling resumes", clk_out, ~prev);
        restore();
    endtask

    task automatic t_pd();
        align();
        step();
        pd_n = 1'b0;
        step(); chk("R5 cycle still runs", clk_out, 4'hF);
        for (int i = 0; i < 4; i++) begin
            step(); chk("R5 parked low", clk_out, 4'h0);
        end
        phase_sel = 4'b1100;
        step(); chk("R5 select ignored while down", clk_out, 4'h0);
        phase_sel = 4'b0011;
        pd_n = 1'b1;
        step(); chk("R6 low on sampling edge", clk_out, 4'h0);
        step(); chk("R6 wake uses same-cycle select", clk_out, 4'b0011);
        step(); chk("R6 second half after wake", clk_out, 4'b1100);
        restore();
    endtask

    initial begin
        t_reset();
        t_steady(4'b0110);
        t_steady(4'b1000);
        t_late(4'b0101);
        t_late(4'b1110);
        t_zero();
        t_pd();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge ref_clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule